// File: doc/BRIEF.md
# I2S Stereo Transmit Channel

This block is one stereo transmit lane of an audio serial controller. Software loads left and right sample words through a small single-cycle register port. Each stored left/right pair goes into a transmit FIFO. The block then drives the pairs onto a serial data line, most significant bit first, in time with two inputs from outside the block: a bit-clock strobe (one system-clock pulse per serial bit) and a word-select level. The block does not generate either of them.

Three enables gate the serial output: a global enable, a transmitter enable and a channel enable. A resolution code sets how many bits of each word are sent. A programmable threshold drives a low-water status flag. Writing a pair into a full FIFO raises a sticky overrun flag, and a read of a dedicated register clears it. A two-bit mask selects which of the two flags reach the interrupt output.

Top module: `i2s_tx_chan`

## Requirements
- R1: After synchronous reset the FIFO level is 0, overrun is 0, all enables and the threshold are 0, the mask reads 0x30, `sdo` is 0 and `irq` is 0.
- R2: `sdo` carries data only while the global, transmitter and channel enables are all 1. Otherwise `sdo` is held at 0 and no pair leaves the FIFO.
- R3: While the channel enable is 0, the FIFO is held empty and pair writes are discarded without raising overrun.
- R4: A word-select falling edge seen at a strobe starts the left word, and a rising edge starts the right word. The MSB appears at the strobe after the edge strobe, and one bit follows per strobe.
- R5: Resolution code (register 3, bits 2:0) sets the width: 1 gives 12 bits, 2 gives 16, 3 gives 20, 4 gives 24, and 5, 0, 6 and 7 give 32. The low width bits of each word are sent MSB first, and any remaining slot bits are sent as 0.
- R6: The FIFO holds 16 pairs in first-in first-out order. A write to register 6 stores the left word and a write to register 7 pushes the pair. A pair is popped at each left-word start. If the FIFO is empty at that point, both words of that frame are sent as 0.
- R7: Status bit 4 (register 8) is 1 exactly when the FIFO level is less than or equal to the threshold (register 4, bits 3:0) plus one.
- R8: A push into a full FIFO with no pop in the same cycle drops the pair and sets status bit 5. A read of status does not clear this bit. A read of register 10 returns it in bit 0 and clears it.
- R9: A push in the same cycle as a pop from a full FIFO is accepted. The level stays at 16, overrun does not rise, and the pushed pair is sent last.
- R10: Writing 1 in bit 0 of register 5 empties the FIFO.
- R11: Mask register 9 uses bit 4 for the empty flag and bit 5 for overrun, where 1 means masked. `irq` is the OR of the unmasked flags.
- R12: Registers 0, 1 and 2 hold the global, transmitter and channel enables in bit 0. Registers 3, 4 and 9 read back as written within their fields. Register 11 returns the FIFO level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (applies read side effects) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from address |
| bit_stb | input | 1 | One-cycle pulse per serial bit period |
| ws_in | input | 1 | Word-select level, sampled at each strobe |
| sdo | output | 1 | Serial data out |
| irq | output | 1 | Interrupt request |

## Verification
The risky overlap is a register push and a serializer pop landing in the same clock, at the moment the FIFO is full. The bench fills all 16 entries. It then asserts the right-word write in the same cycle as the strobe that carries the word-select falling edge. It judges the result on four points: the level reads 16 afterwards, overrun stays clear, and the next 16 frames deliver the old pairs in order followed by the pushed pair last.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 4;
    localparam int PAIR_W = 2 * WORD_W;
    localparam int RES_W  = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_GLOBAL_EN = 4'd0,
        A_TX_EN     = 4'd1,
        A_CHAN_EN   = 4'd2,
        A_RES       = 4'd3,
        A_THRESH    = 4'd4,
        A_FLUSH     = 4'd5,
        A_LEFT      = 4'd6,
        A_RIGHT     = 4'd7,
        A_STATUS    = 4'd8,
        A_MASK      = 4'd9,
        A_OVR_CLR   = 4'd10,
        A_LEVEL     = 4'd11
    } reg_addr_e;

    localparam int BIT_EMPTY = 4;
    localparam int BIT_OVR   = 5;

    typedef struct packed {
        logic [WORD_W-1:0] left;
        logic [WORD_W-1:0] right;
    } sample_pair_t;

    // Sample width selected by a resolution code.
    function automatic int res_width(input logic [RES_W-1:0] code);
        int w;
        case (code)
            3'd1:    w = 12;
            3'd2:    w = 16;
            3'd3:    w = 20;
            3'd4:    w = 24;
            default: w = WORD_W;
        endcase
        return w;
    endfunction

    // Keep the low bits of the word and move them to the MSB end of the slot.
    function automatic logic [WORD_W-1:0] justify(input logic [WORD_W-1:0] d,
                                                  input logic [RES_W-1:0]  code);
        int w;
        logic [WORD_W-1:0] m;
        w = res_width(code);
        m = (w >= WORD_W) ? '1 : ((WORD_W'(1) << w) - WORD_W'(1));
        return (d & m) << (WORD_W - w);
    endfunction

endpackage

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rptr;
    logic             do_push;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign do_pop  = pop && !empty;
    // A full FIFO still takes a push when a slot frees in the same cycle.
    assign do_push = push && (!full || do_pop);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            level <= level + LVL_W'(do_push) - LVL_W'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wptr] <= wdata;
    end

    assign rdata = mem[rptr];

endmodule

// File: rtl/i2s_tx_regs.sv
module i2s_tx_regs
    import i2s_tx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int THR_W = $clog2(DEPTH),
    localparam int LVL_W = THR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              fifo_full,
    input  logic              fifo_pop,
    output logic              glob_en,
    output logic              tx_en,
    output logic              ch_en,
    output logic [RES_W-1:0]  res_code,
    output logic              push,
    output sample_pair_t      push_pair,
    output logic              flush,
    output logic              empty_flag,
    output logic              ovr_flag,
    output logic [1:0]        irq_mask,
    output logic              irq
);

    logic [THR_W-1:0]  thresh;
    logic [WORD_W-1:0] left_hold;
    logic              wr_flush;
    logic              rd_clear;
    logic              ovr_set;

    assign wr_flush = reg_wr && (reg_addr == A_FLUSH) && reg_wdata[0];
    assign rd_clear = reg_rd && (reg_addr == A_OVR_CLR);

    // A disabled channel keeps its FIFO empty.
    assign flush = !ch_en || wr_flush;
    assign push  = reg_wr && (reg_addr == A_RIGHT) && ch_en;
    assign push_pair.left  = left_hold;
    assign push_pair.right = reg_wdata;

    assign ovr_set    = push && fifo_full && !fifo_pop && !flush;
    assign empty_flag = (fifo_level <= ({1'b0, thresh} + LVL_W'(1)));
    assign irq        = (empty_flag && !irq_mask[0]) || (ovr_flag && !irq_mask[1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_en   <= 1'b0;
            tx_en     <= 1'b0;
            ch_en     <= 1'b0;
            res_code  <= '0;
            thresh    <= '0;
            left_hold <= '0;
            irq_mask  <= 2'b11;
            ovr_flag  <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    A_GLOBAL_EN: glob_en   <= reg_wdata[0];
                    A_TX_EN:     tx_en     <= reg_wdata[0];
                    A_CHAN_EN:   ch_en     <= reg_wdata[0];
                    A_RES:       res_code  <= reg_wdata[RES_W-1:0];
                    A_THRESH:    thresh    <= reg_wdata[THR_W-1:0];
                    A_LEFT:      left_hold <= reg_wdata;
                    A_MASK:      irq_mask  <= reg_wdata[BIT_OVR:BIT_EMPTY];
                    default: ;
                endcase
            end
            // Setting takes priority over a clearing read in the same cycle.
            if (ovr_set)       ovr_flag <= 1'b1;
            else if (rd_clear) ovr_flag <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_GLOBAL_EN: reg_rdata[0] = glob_en;
            A_TX_EN:     reg_rdata[0] = tx_en;
            A_CHAN_EN:   reg_rdata[0] = ch_en;
            A_RES:       reg_rdata[RES_W-1:0] = res_code;
            A_THRESH:    reg_rdata[THR_W-1:0] = thresh;
            A_LEFT:      reg_rdata = left_hold;
            A_STATUS: begin
                reg_rdata[BIT_EMPTY] = empty_flag;
                reg_rdata[BIT_OVR]   = ovr_flag;
            end
            A_MASK:      reg_rdata[BIT_OVR:BIT_EMPTY] = irq_mask;
            A_OVR_CLR:   reg_rdata[0] = ovr_flag;
            A_LEVEL:     reg_rdata[LVL_W-1:0] = fifo_level;
            default: ;
        endcase
    end

endmodule

// File: rtl/i2s_tx_ser.sv
module i2s_tx_ser
    import i2s_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             bit_stb,
    input  logic             ws_in,
    input  logic [RES_W-1:0] res_code,
    input  sample_pair_t     head,
    input  logic             fifo_empty,
    output logic             pop,
    output logic             sdo
);

    logic              ws_q;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] right_hold;
    logic              ws_fall;
    logic              ws_rise;

    assign ws_fall = bit_stb && ws_q && !ws_in;
    assign ws_rise = bit_stb && !ws_q && ws_in;
    assign pop     = ws_fall && active && !fifo_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            ws_q       <= 1'b0;
            shreg      <= '0;
            right_hold <= '0;
            sdo        <= 1'b0;
        end else begin
            if (bit_stb) ws_q <= ws_in;
            if (!active) begin
                sdo        <= 1'b0;
                shreg      <= '0;
                right_hold <= '0;
            end else if (bit_stb) begin
                // One-bit lag: the edge strobe still drives the previous slot.
                sdo <= shreg[WORD_W-1];
                if (ws_fall) begin
                    if (pop) begin
                        shreg      <= justify(head.left, res_code);
                        right_hold <= head.right;
                    end else begin
                        shreg      <= '0;
                        right_hold <= '0;
                    end
                end else if (ws_rise) begin
                    shreg <= justify(right_hold, res_code);
                end else begin
                    shreg <= {shreg[WORD_W-2:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/i2s_tx_chan.sv
module i2s_tx_chan
    import i2s_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int LVL_W = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              bit_stb,
    input  logic              ws_in,
    output logic              sdo,
    output logic              irq
);

    logic              glob_en;
    logic              tx_en;
    logic              ch_en;
    logic              active;
    logic [RES_W-1:0]  res_code;
    logic              push;
    sample_pair_t      push_pair;
    logic              flush;
    logic              empty_flag;
    logic              ovr_flag;
    logic [1:0]        irq_mask;
    logic [LVL_W-1:0]  fifo_level;
    logic              fifo_full;
    logic              fifo_empty;
    logic              pop;
    logic [PAIR_W-1:0] fifo_rdata;
    sample_pair_t      head;

    assign active = glob_en && tx_en && ch_en;
    assign head   = sample_pair_t'(fifo_rdata);

    i2s_tx_regs #(.DEPTH(FIFO_DEPTH)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .fifo_level (fifo_level),
        .fifo_full  (fifo_full),
        .fifo_pop   (pop),
        .glob_en    (glob_en),
        .tx_en      (tx_en),
        .ch_en      (ch_en),
        .res_code   (res_code),
        .push       (push),
        .push_pair  (push_pair),
        .flush      (flush),
        .empty_flag (empty_flag),
        .ovr_flag   (ovr_flag),
        .irq_mask   (irq_mask),
        .irq        (irq)
    );

    i2s_tx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(PAIR_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .push  (push),
        .wdata (push_pair),
        .pop   (pop),
        .rdata (fifo_rdata),
        .level (fifo_level),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    i2s_tx_ser u_ser (
        .clk        (clk),
        .rst        (rst),
        .active     (active),
        .bit_stb    (bit_stb),
        .ws_in      (ws_in),
        .res_code   (res_code),
        .head       (head),
        .fifo_empty (fifo_empty),
        .pop        (pop),
        .sdo        (sdo)
    );

endmodule

// File: rtl/i2s_tx_chan_chk.sv
module i2s_tx_chan_chk #(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_rd,
    input logic [3:0]       reg_addr,
    input logic             active,
    input logic             ch_en,
    input logic [LVL_W-1:0] fifo_level,
    input logic             fifo_full,
    input logic             push,
    input logic             pop,
    input logic             ovr_flag,
    input logic             empty_flag,
    input logic [1:0]       irq_mask,
    input logic             irq,
    input logic             sdo
);

    logic rst_q;

    always_ff @(posedge clk) rst_q <= rst;

    always @(posedge clk) begin
        if (rst_q === 1'b1) begin
            assert_reset_state_R1: assert (fifo_level == '0 && !sdo && !irq && !ovr_flag)
                else $error("reset state violated");
        end
    end

    assert_gated_sdo_R2: assert property (@(posedge clk) disable iff (rst)
        !active |=> !sdo);

    assert_gated_pop_R2: assert property (@(posedge clk) disable iff (rst)
        !active |-> !pop);

    assert_chan_off_empty_R3: assert property (@(posedge clk) disable iff (rst)
        !ch_en |=> (fifo_level == '0));

    assert_level_bound_R6: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= LVL_W'(DEPTH));

    assert_empty_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (fifo_level == '0) |-> empty_flag);

    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (ovr_flag && !(reg_rd && reg_addr == 4'd10)) |=> ovr_flag);

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && push && pop && !ovr_flag) |=> !ovr_flag);

    assert_irq_masked_R11: assert property (@(posedge clk) disable iff (rst)
        (irq_mask == 2'b11) |-> !irq);

endmodule

bind i2s_tx_chan i2s_tx_chan_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .active     (active),
    .ch_en      (ch_en),
    .fifo_level (fifo_level),
    .fifo_full  (fifo_full),
    .push       (push),
    .pop        (pop),
    .ovr_flag   (ovr_flag),
    .empty_flag (empty_flag),
    .irq_mask   (irq_mask),
    .irq        (irq),
    .sdo        (sdo)
);

// File: tb/i2s_tx_chan_bench.sv
module i2s_tx_chan_bench;

    localparam int DEPTH = 16;
    localparam logic [3:0] RG_GLOB = 4'd0, RG_TX = 4'd1, RG_CH = 4'd2, RG_RES = 4'd3,
                           RG_THR = 4'd4, RG_FLUSH = 4'd5, RG_LEFT = 4'd6, RG_RIGHT = 4'd7,
                           RG_STAT = 4'd8, RG_MASK = 4'd9, RG_OCLR = 4'd10, RG_LVL = 4'd11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bit_stb = 1'b0;
    logic        ws_in = 1'b1;
    logic        sdo;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    i2s_tx_chan #(.FIFO_DEPTH(DEPTH)) u_i2s_tx_chan (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bit_stb(bit_stb), .ws_in(ws_in),
        .sdo(sdo), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic push_pair(input logic [31:0] l, input logic [31:0] r);
        wr(RG_LEFT, l);
        wr(RG_RIGHT, r);
    endtask

    // 32 strobes with word-select low, then 33 with it high so the right LSB lands.
    task automatic run_frame(input bit cpush, input logic [31:0] cword,
                             output logic [31:0] l, output logic [31:0] r);
        l = '0; r = '0;
        for (int j = 0; j < 65; j++) begin
            @(negedge clk);
            bit_stb = 1'b1;
            ws_in = (j >= 32);
            if (j == 0 && cpush) begin
                reg_wr = 1'b1; reg_addr = RG_RIGHT; reg_wdata = cword;
            end
            @(negedge clk);
            bit_stb = 1'b0;
            reg_wr = 1'b0;
            if (j >= 1 && j <= 32) l = {l[30:0], sdo};
            else if (j >= 33) r = {r[30:0], sdo};
        end
    endtask

    function automatic logic [31:0] expect_word(input logic [31:0] d, input int code);
        int w;
        case (code)
            1: w = 12;
            2: w = 16;
            3: w = 20;
            4: w = 24;
            default: w = 32;
        endcase
        if (w == 32) return d;
        return (d & ((32'd1 << w) - 32'd1)) << (32 - w);
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, l, r;
        logic [31:0] pats [4];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5C3_96E1;
        pats[2] = 32'h8000_0001; pats[3] = 32'h1234_5678;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 sdo", {31'd0, sdo}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd(RG_LVL, v);  chk("R1 level", v, 32'd0);
        rd(RG_STAT, v); chk("R1 status", v, 32'h10);
        rd(RG_MASK, v); chk("R1 mask", v, 32'h30);
        rd(RG_GLOB, v); chk("R1 global enable", v, 32'd0);
        rd(RG_THR, v);  chk("R1 threshold", v, 32'd0);

        // R12 read-back
        wr(RG_RES, 32'd5);  rd(RG_RES, v);  chk("R12 resolution", v, 32'd5);
        wr(RG_THR, 32'd7);  rd(RG_THR, v);  chk("R12 threshold", v, 32'd7);
        wr(RG_MASK, 32'hFFFF_FFFF); rd(RG_MASK, v); chk("R12 mask", v, 32'h30);
        wr(RG_THR, 32'd0);

        wr(RG_GLOB, 32'd1); wr(RG_TX, 32'd1); wr(RG_CH, 32'd1);
        rd(RG_CH, v); chk("R12 channel enable", v, 32'd1);

        // prime word-select high
        @(negedge clk); bit_stb = 1'b1; ws_in = 1'b1;
        @(negedge clk); bit_stb = 1'b0;

        // R4 R5 resolution sweep
        for (int code = 0; code < 8; code++) begin
            wr(RG_RES, 32'(code));
            for (int p = 0; p < 4; p++) begin
                push_pair(pats[p], ~pats[p]);
                run_frame(1'b0, '0, l, r);
                chk($sformatf("R4 R5 left code %0d", code), l, expect_word(pats[p], code));
                chk($sformatf("R4 R5 right code %0d", code), r, expect_word(~pats[p], code));
            end
        end
        wr(RG_RES, 32'd5);

        // R6 order and empty frame
        for (int k = 0; k < 3; k++) push_pair(32'h1111_1111 * (k + 1), 32'h0F0F_0000 + k);
        rd(RG_LVL, v); chk("R6 level after 3 pushes", v, 32'd3);
        for (int k = 0; k < 3; k++) begin
            run_frame(1'b0, '0, l, r);
            chk("R6 order left", l, 32'h1111_1111 * (k + 1));
            chk("R6 order right", r, 32'h0F0F_0000 + k);
        end
        run_frame(1'b0, '0, l, r);
        chk("R6 empty frame left", l, 32'd0);
        chk("R6 empty frame right", r, 32'd0);

        // R2 enable gating
        push_pair(32'hDEAD_BEEF, 32'h0BAD_F00D);
        wr(RG_GLOB, 32'd0);
        run_frame(1'b0, '0, l, r);
        chk("R2 global off sdo", l | r, 32'd0);
        rd(RG_LVL, v); chk("R2 global off no pop", v, 32'd1);
        wr(RG_GLOB, 32'd1); wr(RG_TX, 32'd0);
        run_frame(1'b0, '0, l, r);
        chk("R2 tx off sdo", l | r, 32'd0);
        rd(RG_LVL, v); chk("R2 tx off no pop", v, 32'd1);
        wr(RG_TX, 32'd1);
        run_frame(1'b0, '0, l, r);
        chk("R2 re-enabled left", l, 32'hDEAD_BEEF);
        chk("R2 re-enabled right", r, 32'h0BAD_F00D);

        // R3 channel disable
        push_pair(32'h1, 32'h2); push_pair(32'h3, 32'h4);
        wr(RG_CH, 32'd0);
        rd(RG_LVL, v); chk("R3 flushed on disable", v, 32'd0);
        push_pair(32'h5, 32'h6);
        rd(RG_LVL, v); chk("R3 write discarded", v, 32'd0);
        rd(RG_STAT, v); chk("R3 no overrun", v & 32'h20, 32'd0);
        run_frame(1'b0, '0, l, r);
        chk("R3 disabled sdo", l | r, 32'd0);
        wr(RG_CH, 32'd1);
        run_frame(1'b0, '0, l, r);
        chk("R3 nothing retained", l | r, 32'd0);

        // R7 threshold sweep
        for (int thr = 0; thr < 16; thr++) begin
            wr(RG_THR, 32'(thr));
            wr(RG_FLUSH, 32'd1);
            for (int lvl = 0; lvl <= 16; lvl++) begin
                rd(RG_STAT, v);
                chk($sformatf("R7 thr %0d level %0d", thr, lvl), v & 32'h10,
                    (lvl <= thr + 1) ? 32'h10 : 32'h0);
                if (lvl < 16) push_pair(32'(lvl), 32'(thr));
            end
        end

        // R8 overrun
        wr(RG_THR, 32'd0);
        rd(RG_STAT, v); chk("R8 no overrun yet", v, 32'd0);
        push_pair(32'hFFFF_0000, 32'h0000_FFFF);
        rd(RG_LVL, v);  chk("R8 level stays full", v, 32'd16);
        rd(RG_STAT, v); chk("R8 overrun set", v, 32'h20);
        rd(RG_STAT, v); chk("R8 status read keeps overrun", v, 32'h20);
        rd(RG_OCLR, v); chk("R8 clear read value", v, 32'd1);
        rd(RG_STAT, v); chk("R8 cleared", v, 32'd0);

        // R11 masking
        push_pair(32'h7, 32'h8);
        wr(RG_MASK, 32'h30); chk("R11 both masked", {31'd0, irq}, 32'd0);
        wr(RG_MASK, 32'h10); chk("R11 overrun unmasked", {31'd0, irq}, 32'd1);
        wr(RG_MASK, 32'h20); chk("R11 empty unmasked, not empty", {31'd0, irq}, 32'd0);
        rd(RG_OCLR, v);
        wr(RG_MASK, 32'h00); chk("R11 no flags", {31'd0, irq}, 32'd0);

        // R10 flush
        wr(RG_FLUSH, 32'd1);
        rd(RG_LVL, v); chk("R10 flush empties", v, 32'd0);
        chk("R11 empty raises irq", {31'd0, irq}, 32'd1);
        wr(RG_MASK, 32'h30); chk("R11 masked again", {31'd0, irq}, 32'd0);
        run_frame(1'b0, '0, l, r);
        chk("R10 flushed frame", l | r, 32'd0);

        // R9 push and pop in one cycle at full
        for (int k = 0; k < 16; k++) push_pair(32'h1000 + k, 32'h2000 + k);
        rd(RG_LVL, v); chk("R9 full before", v, 32'd16);
        wr(RG_LEFT, 32'hCAFE_F00D);
        run_frame(1'b1, 32'hBEEF_0001, l, r);
        chk("R9 head left", l, 32'h1000);
        chk("R9 head right", r, 32'h2000);
        rd(RG_LVL, v);  chk("R9 level after", v, 32'd16);
        rd(RG_STAT, v); chk("R9 no overrun", v & 32'h20, 32'd0);
        for (int k = 1; k < 16; k++) begin
            run_frame(1'b0, '0, l, r);
            chk("R9 drain left", l, 32'h1000 + k);
            chk("R9 drain right", r, 32'h2000 + k);
        end
        run_frame(1'b0, '0, l, r);
        chk("R9 pushed pair left", l, 32'hCAFE_F00D);
        chk("R9 pushed pair right", r, 32'hBEEF_0001);
        run_frame(1'b0, '0, l, r);
        chk("R6 drained empty", l | r, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule